// File: doc/BRIEF.md
# IO Expander Pin-Change Interrupt

This block watches the pins of an I/O expander that is split into equal-width ports. It raises a shared, active-low interrupt when any pin set up as an input changes level. Each port keeps a reference copy of its last-read input levels. A port's pending flag is set whenever a synchronized input pin differs from that copy. The flag drops again in two cases: every differing pin returns to its stored level, or the bus side reads the port.

The I2C slave engine reports each read of a port's input register with a one-cycle strobe. The strobe is issued in the acknowledge cycle, just before that port's data byte is shifted out. On that strobe the block clears the port's pending flag and reloads its reference copy from the current synchronized levels. Every other bus activity produces no strobe, so it leaves the interrupt state alone. The interrupt line is modelled as a pull-low enable for an open-drain driver with an external pull-up.

Top module: `ioexp_chg_irq`

## Requirements
- R1: While reset is asserted, and for the cycles after release while the reference copies load from the synchronized pins, `irq_pull_en` is 0. Pins that are held steady through reset never raise an interrupt, whatever their levels are.
- R2: A rising or a falling level change on a pin whose `pin_is_input` bit is 1 sets `irq_pull_en` to 1. The change appears after exactly SYNC_STAGES+1 rising clock edges and not earlier.
- R3: A pin whose `pin_is_input` bit is 0 (output) never causes an interrupt, whatever its level does.
- R4: A 1 on `port_rd_ack[p]` at a clock edge clears port p's pending flag at that edge. The same edge reloads port p's reference copy from the synchronized levels of its pins. If no other port is pending, `irq_pull_en` is 0 right after that edge.
- R5: A strobe on `port_rd_ack[p]` never clears a pending flag of another port. Pin i of port p is bit p*PORT_W+i of `pin_lvl`.
- R6: If every changed input pin of a port goes back to its reference level, that port's pending flag clears without any read. This happens SYNC_STAGES+1 edges after the pins return.
- R7: Switching a pin from output to input while its synchronized level differs from its reference bit raises the interrupt on the next clock edge.
- R8: Without a strobe, a pending interrupt stays asserted indefinitely. Bus traffic for other devices and writes to this device produce no strobe, so they have no effect.
- R9: A pin change that races a read strobe may be absorbed into the reloaded reference or may raise a later interrupt; either outcome is accepted. A further read of that port with steady pins leaves it clear.
- R10: The interrupt is expressed only as a pull-low enable. A 1 means the line is driven low and a 0 means it is released. The line is never driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | NUM_PORTS*PORT_W | Raw pin levels, port p at bits p*PORT_W upward |
| pin_is_input | input | NUM_PORTS*PORT_W | Per-pin direction, 1 = input, 0 = output |
| port_rd_ack | input | NUM_PORTS | Per-port read strobe at the acknowledge cycle of an input-register read |
| irq_pull_en | output | 1 | 1 pulls the open-drain interrupt line low, 0 releases it |

## Verification
The bench builds the block with its defaults: two 8-bit ports and a two-flop synchronizer. With two ports it can show that a read of one port leaves the other port's interrupt pending. With the fixed three-edge input latency it can check the first cycle the interrupt appears and the cycle it goes away after a pin reverts. Toggling a pin while it is an output and then turning it into an input covers both the masking and the false interrupt on a direction switch.

// File: rtl/ioexp_irq_pkg.sv
package ioexp_irq_pkg;

  // Arming phase of the change detector after reset release.
  typedef enum logic {
    ARM_LOAD = 1'b0,   // reference copies still tracking the synchronizer
    ARM_RUN  = 1'b1    // comparisons live
  } arm_state_e;

  // Count width able to hold values 0..max_val.
  function automatic int unsigned cnt_bits(input int unsigned max_val);
    int unsigned b;
    b = 1;
    while ((1 << b) <= max_val) b++;
    return b;
  endfunction

endpackage

// File: rtl/ioexp_pin_sync.sv
module ioexp_pin_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= raw_i;
  end

  // Remaining flops of the chain.
  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/ioexp_arm_ctrl.sv
module ioexp_arm_ctrl
  import ioexp_irq_pkg::*;
#(
  parameter int unsigned LOAD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic armed_o
);

  localparam int unsigned CW = cnt_bits(LOAD_CYC);

  arm_state_e     state_q;
  logic [CW-1:0]  cnt_q;
  logic           last_load;

  assign last_load = (cnt_q == CW'(LOAD_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARM_LOAD;
      cnt_q   <= '0;
    end else if (state_q == ARM_LOAD) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_load) state_q <= ARM_RUN;
    end
  end

  assign armed_o = (state_q == ARM_RUN);

  // R1: arming happens once and never reverts outside reset
  p_armed_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o |=> armed_o);

endmodule

// File: rtl/ioexp_port_watch.sv
module ioexp_port_watch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         armed_i,
  input  logic [W-1:0] pins_s_i,
  input  logic [W-1:0] is_input_i,
  input  logic         rd_ack_i,
  output logic         pending_o
);

  logic [W-1:0] ref_q;
  logic         pend_q;
  logic [W-1:0] live_diff;   // input pins that differ from the reference
  logic         reload_evt;  // reference reload this edge
  logic         differs;

  // Pins whose synchronized level disagrees with the reference, masked to inputs.
  function automatic logic [W-1:0] diff_mask(input logic [W-1:0] now_v,
                                             input logic [W-1:0] ref_v,
                                             input logic [W-1:0] msk);
    return (now_v ^ ref_v) & msk;
  endfunction

  function automatic logic any_set(input logic [W-1:0] v);
    return |v;
  endfunction

  assign live_diff  = diff_mask(pins_s_i, ref_q, is_input_i);
  assign differs    = any_set(live_diff);
  assign reload_evt = !armed_i || rd_ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      pend_q <= 1'b0;
    end else if (reload_evt) begin
      ref_q  <= pins_s_i;
      pend_q <= 1'b0;
    end else begin
      pend_q <= differs;
    end
  end

  assign pending_o = pend_q;

  // R4: a read strobe leaves the port clear after that edge
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack_i |=> !pending_o);

  // R4: the reference takes the synchronized levels seen at the strobe edge
  p_ack_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack_i |=> (ref_q == $past(pins_s_i)));

  // R3: with every pin an output, nothing can become pending
  p_out_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_i && (is_input_i == '0)) |=> !pending_o);

  // R8: without a strobe the reference is left untouched
  p_ref_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_i && !rd_ack_i) |=> $stable(ref_q));

  // R6: pins agreeing with the reference leave the port clear
  p_revert_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_i && (pins_s_i == ref_q)) |=> !pending_o);

endmodule

// File: rtl/ioexp_chg_irq.sv
module ioexp_chg_irq #(
  parameter int unsigned NUM_PORTS   = 2,
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_lvl,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_is_input,
  input  logic [NUM_PORTS-1:0]          port_rd_ack,
  output logic                          irq_pull_en
);

  localparam int unsigned PIN_CNT  = NUM_PORTS * PORT_W;
  localparam int unsigned LOAD_CYC = SYNC_STAGES + 1;

  logic [PIN_CNT-1:0]   pins_s;
  logic                 armed;
  logic [NUM_PORTS-1:0] port_pend;

  ioexp_pin_sync #(
    .WIDTH  (PIN_CNT),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pin_lvl),
    .sync_o (pins_s)
  );

  ioexp_arm_ctrl #(
    .LOAD_CYC (LOAD_CYC)
  ) u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed_o (armed)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    ioexp_port_watch #(
      .W (PORT_W)
    ) u_watch (
      .clk        (clk),
      .rst_n      (rst_n),
      .armed_i    (armed),
      .pins_s_i   (pins_s[p*PORT_W +: PORT_W]),
      .is_input_i (pin_is_input[p*PORT_W +: PORT_W]),
      .rd_ack_i   (port_rd_ack[p]),
      .pending_o  (port_pend[p])
    );
  end

  // Open-drain line: any pending port pulls it low.
  assign irq_pull_en = |port_pend;

  // R1: nothing is signalled while references are loading
  p_quiet_loading_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !irq_pull_en);

  // R3: the interrupt can only rise if some pin was an input
  p_rise_needs_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pull_en) |-> $past(|pin_is_input));

  // R10: the enable is always a defined level
  p_enable_known_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(irq_pull_en));

endmodule

// File: tb/ioexp_chg_irq_test.sv
`timescale 1ns/1ps
module ioexp_chg_irq_test;

  localparam int unsigned NP  = 2;
  localparam int unsigned PW  = 8;
  localparam int unsigned SS  = 2;
  localparam int unsigned NPIN = NP * PW;
  localparam int unsigned LAT = SS + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NPIN-1:0] pins = 16'hA53C;
  logic [NPIN-1:0] dir  = '1;
  logic [NP-1:0]   ack  = '0;
  logic            irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ioexp_chg_irq #(.NUM_PORTS(NP), .PORT_W(PW), .SYNC_STAGES(SS)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_lvl      (pins),
    .pin_is_input (dir),
    .port_rd_ack  (ack),
    .irq_pull_en  (irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_pull_en=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // One-cycle read strobe for port p; returns at the negedge after the edge.
  task automatic read_port(input int p);
    ack[p] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ack[p] = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 during reset", irq, 1'b0);
    chk("R10 released in reset", irq, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    settle(8);
    chk("R1 steady nonzero pins after release", irq, 1'b0);
  endtask

  task automatic t_rise_fall;
    pins[1] = ~pins[1];            // bit1 of 0x3C is 0: rising
    settle(LAT - 1);
    chk("R2 not before latency", irq, 1'b0);
    settle(1);
    chk("R2 rising edge", irq, 1'b1);
    read_port(0);
    chk("R4 clear at read", irq, 1'b0);
    settle(2);
    chk("R4 stays clear after reload", irq, 1'b0);
    pins[1] = ~pins[1];            // falling
    settle(LAT);
    chk("R2 falling edge", irq, 1'b1);
    read_port(0);
    settle(2);
    chk("R4 clear after second read", irq, 1'b0);
  endtask

  task automatic t_mask_then_switch;
    dir[8] = 1'b0;
    @(negedge clk);
    pins[8] = ~pins[8];
    settle(LAT + 3);
    chk("R3 output pin masked", irq, 1'b0);
    dir[8] = 1'b1;
    settle(1);
    chk("R7 output-to-input mismatch", irq, 1'b1);
    read_port(1);
    settle(2);
    chk("R4 port1 read clears", irq, 1'b0);
  endtask

  task automatic t_revert;
    pins[2] = ~pins[2];
    settle(LAT);
    chk("R6 pending before revert", irq, 1'b1);
    pins[2] = ~pins[2];
    settle(LAT - 1);
    chk("R6 still pending before return seen", irq, 1'b1);
    settle(1);
    chk("R6 self-clear on revert", irq, 1'b0);
  endtask

  task automatic t_independent;
    pins[12] = ~pins[12];
    settle(LAT);
    chk("R5 port1 change pending", irq, 1'b1);
    read_port(0);
    settle(2);
    chk("R5 port0 read keeps port1 pending", irq, 1'b1);
    read_port(1);
    chk("R5 port1 read clears", irq, 1'b0);
  endtask

  task automatic t_hold;
    pins[5] = ~pins[5];
    settle(LAT);
    chk("R8 pending", irq, 1'b1);
    settle(60);
    chk("R8 held without strobe", irq, 1'b1);
    read_port(0);
    settle(2);
    chk("R8 cleared only by read", irq, 1'b0);
  endtask

  task automatic t_race;
    pins[6] = ~pins[6];
    read_port(0);
    settle(LAT + 2);
    n_chk++;                       // R9: both outcomes accepted
    if (irq !== 1'b0 && irq !== 1'b1) begin
      n_fail++;
      $display("FAIL R9 race outcome: irq_pull_en=%b expected 0 or 1", irq);
    end
    read_port(0);
    settle(2);
    chk("R9 follow-up read clears", irq, 1'b0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    t_rise_fall();
    t_mask_then_switch();
    t_revert();
    t_independent();
    t_hold();
    t_race();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule